// File: doc/BRIEF.md
# Weighted Centroid Defuzzifier

This block turns a stream of weighted rule consequents into crisp output values by the center-of-gravity method with product (MAX-DOT) scaling. Each incoming term carries a rule weight (omega) and the index of a consequent. The block reads two precomputed figures for that consequent from an external table: the consequent's area at full truth level, and that area multiplied by its centroid. Both figures are scaled by the weight, and two accumulators run side by side to form the numerator and the denominator. A flag on the last term of a group closes that output variable and hands the two sums to a sequential divider.

Results leave one at a time on a 10-bit bus with a 4-bit output number, a one-cycle strobe and an end-of-processing flag. The flag rises early, once the next-to-last result of a round has been delivered, so a host can start gathering fresh inputs while the final division still runs. A round holds `cfg_last_idx + 1` outputs, numbered from zero.

The term input is a valid/ready stream. A term transfers on a rising clock edge where `in_valid` and `in_ready` are both high. While `in_valid` is high and `in_ready` is low, the source must hold `in_valid`, `in_omega`, `in_cidx` and `in_last` unchanged. `in_ready` drops only while a completed group waits for the divider to become free. The result side has no back-pressure: each result is offered for one cycle only.

Top module: `maxdot_defuzzifier`

## Requirements
- R1: A term transfers on a rising edge with `in_valid` and `in_ready` both high. `in_ready` is high after reset. It goes low only while the term held in the input stage closes a group and the divider is still working on the previous group.
- R2: In the cycle after a term is accepted, `cons_addr` equals that term's `in_cidx`. The table answers `cons_area` and `cons_moment` for `cons_addr` in the same cycle, with no clock in between.
- R3: For each group of terms, ended by a term with `in_last` = 1, `out_value` is floor(sum(omega*moment) / sum(omega*area)) over the terms of the group.
- R4: When the group's weighted area sum is zero, the result is 0.
- R5: When the quotient exceeds 1023, the result is 1023.
- R6: With 8-bit weights, 8-bit areas and 18-bit moments, a group of up to 16 terms all at their maximum values gives the exact quotient, with no accumulator wrap. A group must not hold more than 16 terms.
- R7: `out_strobe` is high for exactly one clock per result, and two strobes are never in adjacent cycles.
- R8: `out_value` and `out_index` take their new values in the strobe cycle and hold them until the next strobe.
- R9: `out_index` counts 0, 1, ..., `cfg_last_idx` over the results of a round, then starts again at 0.
- R10: With `cfg_last_idx` > 0, `out_eop` is high from the cycle after the strobe of output `cfg_last_idx - 1` through the strobe cycle of output `cfg_last_idx`, and low in the cycle after that. With `cfg_last_idx` = 0, `out_eop` is high only in the strobe cycle.
- R11: After reset, `out_strobe`, `out_eop`, `out_value` and `out_index` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_last_idx | input | 4 | Number of outputs per round minus one |
| in_valid | input | 1 | Term stream valid |
| in_ready | output | 1 | Term stream ready |
| in_omega | input | 8 | Rule weight of the term |
| in_cidx | input | 5 | Consequent index of the term |
| in_last | input | 1 | Term closes the current output group |
| cons_addr | output | 5 | Consequent table read address |
| cons_area | input | 8 | Table answer: area at full truth level |
| cons_moment | input | 18 | Table answer: area times centroid |
| out_strobe | output | 1 | One-cycle pulse, new result valid |
| out_value | output | 10 | Crisp result |
| out_index | output | 4 | Number of the result within the round |
| out_eop | output | 1 | End-of-processing flag |

## Verification
The assertions take three things for granted about the inputs. A stalled term is held steady on the stream. No group holds more than 16 terms. `cfg_last_idx` changes only between complete rounds. The bench drives terms through one handshake task that keeps every field fixed until the transfer edge. It builds groups of 16 terms or fewer, and it changes `cfg_last_idx` only after all results of the previous round have been collected. The table model derives each area and moment from its index, with two entries made to force saturation and the largest products.

// File: rtl/maxdot_defuz_pkg.sv
package maxdot_defuz_pkg;
  localparam int WGT_W     = 8;
  localparam int AREA_W    = 8;
  localparam int MOM_W     = 18;
  localparam int OUT_W     = 10;
  localparam int IDX_W     = 4;
  localparam int CIDX_W    = 5;
  localparam int MAX_TERMS = 16;

  typedef enum logic [1:0] {
    DV_IDLE  = 2'd0,
    DV_CHECK = 2'd1,
    DV_RUN   = 2'd2
  } div_state_e;
endpackage

// File: rtl/maxdot_term_stage.sv
module maxdot_term_stage #(
  parameter int WGT_W  = 8,
  parameter int CIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WGT_W-1:0]  in_omega,
  input  logic [CIDX_W-1:0] in_cidx,
  input  logic              in_last,
  input  logic              hold,
  output logic              s_valid,
  output logic [WGT_W-1:0]  s_omega,
  output logic [CIDX_W-1:0] s_cidx,
  output logic              s_last,
  output logic              s_fire
);
  assign s_fire   = s_valid && !hold;
  assign in_ready = !s_valid || s_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_valid <= 1'b0;
      s_omega <= '0;
      s_cidx  <= '0;
      s_last  <= 1'b0;
    end else if (in_ready) begin
      s_valid <= in_valid;
      if (in_valid) begin
        s_omega <= in_omega;
        s_cidx  <= in_cidx;
        s_last  <= in_last;
      end
    end
  end
endmodule

// File: rtl/maxdot_mac_lane.sv
module maxdot_mac_lane #(
  parameter int WGT_W  = 8,
  parameter int TERM_W = 18,
  parameter int ACC_W  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              step_last,
  input  logic [WGT_W-1:0]  weight,
  input  logic [TERM_W-1:0] term,
  output logic [ACC_W-1:0]  total
);
  localparam int PROD_W = WGT_W + TERM_W;

  logic [PROD_W-1:0] prod;
  logic [ACC_W-1:0]  acc_q;

  assign prod  = weight * term;
  assign total = acc_q + ACC_W'(prod);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (step) begin
      acc_q <= step_last ? '0 : total;
    end
  end
endmodule

// File: rtl/maxdot_divider.sv
module maxdot_divider
  import maxdot_defuz_pkg::*;
#(
  parameter int NUM_W = 31,
  parameter int DEN_W = 21,
  parameter int Q_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [Q_W-1:0]   quot
);
  localparam int WIDE_W = (NUM_W > DEN_W + Q_W) ? NUM_W : DEN_W + Q_W;
  localparam int CNT_W  = $clog2(Q_W);

  div_state_e         state_q;
  logic [WIDE_W-1:0]  rem_q;
  logic [WIDE_W-1:0]  dsh_q;
  logic [DEN_W-1:0]   den_q;
  logic [Q_W-1:0]     q_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               done_q;

  assign busy = (state_q != DV_IDLE);
  assign done = done_q;
  assign quot = q_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DV_IDLE;
      rem_q   <= '0;
      dsh_q   <= '0;
      den_q   <= '0;
      q_q     <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        DV_IDLE: begin
          if (start) begin
            rem_q   <= WIDE_W'(num);
            den_q   <= den;
            state_q <= DV_CHECK;
          end
        end
        DV_CHECK: begin
          if (den_q == '0) begin
            q_q     <= '0;
            done_q  <= 1'b1;
            state_q <= DV_IDLE;
          end else if ((WIDE_W'(den_q) << Q_W) <= rem_q) begin
            q_q     <= '1;
            done_q  <= 1'b1;
            state_q <= DV_IDLE;
          end else begin
            dsh_q   <= WIDE_W'(den_q) << (Q_W - 1);
            cnt_q   <= CNT_W'(Q_W - 1);
            state_q <= DV_RUN;
          end
        end
        DV_RUN: begin
          if (rem_q >= dsh_q) begin
            rem_q <= rem_q - dsh_q;
            q_q   <= {q_q[Q_W-2:0], 1'b1};
          end else begin
            q_q   <= {q_q[Q_W-2:0], 1'b0};
          end
          dsh_q <= dsh_q >> 1;
          if (cnt_q == '0) begin
            done_q  <= 1'b1;
            state_q <= DV_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= DV_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/maxdot_defuzzifier.sv
module maxdot_defuzzifier
  import maxdot_defuz_pkg::*;
#(
  parameter int P_WGT_W     = WGT_W,
  parameter int P_AREA_W    = AREA_W,
  parameter int P_MOM_W     = MOM_W,
  parameter int P_OUT_W     = OUT_W,
  parameter int P_IDX_W     = IDX_W,
  parameter int P_CIDX_W    = CIDX_W,
  parameter int P_MAX_TERMS = MAX_TERMS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [P_IDX_W-1:0]  cfg_last_idx,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [P_WGT_W-1:0]  in_omega,
  input  logic [P_CIDX_W-1:0] in_cidx,
  input  logic                in_last,
  output logic [P_CIDX_W-1:0] cons_addr,
  input  logic [P_AREA_W-1:0] cons_area,
  input  logic [P_MOM_W-1:0]  cons_moment,
  output logic                out_strobe,
  output logic [P_OUT_W-1:0]  out_value,
  output logic [P_IDX_W-1:0]  out_index,
  output logic                out_eop
);
  localparam int GUARD_W = $clog2(P_MAX_TERMS + 1);
  localparam int NUM_W   = P_WGT_W + P_MOM_W + GUARD_W;
  localparam int DEN_W   = P_WGT_W + P_AREA_W + GUARD_W;

  logic                s_valid, s_last, s_fire, hold;
  logic [P_WGT_W-1:0]  s_omega;
  logic [P_CIDX_W-1:0] s_cidx;
  logic [NUM_W-1:0]    num_total;
  logic [DEN_W-1:0]    den_total;
  logic                div_start, div_busy, div_done;
  logic [P_OUT_W-1:0]  div_quot;

  logic                strobe_q, eop_q;
  logic [P_OUT_W-1:0]  value_q;
  logic [P_IDX_W-1:0]  index_q, next_idx_q;

  assign hold      = s_last && div_busy;
  assign div_start = s_valid && s_last && !div_busy;
  assign cons_addr = s_cidx;

  maxdot_term_stage #(.WGT_W(P_WGT_W), .CIDX_W(P_CIDX_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_omega (in_omega),
    .in_cidx  (in_cidx),
    .in_last  (in_last),
    .hold     (hold),
    .s_valid  (s_valid),
    .s_omega  (s_omega),
    .s_cidx   (s_cidx),
    .s_last   (s_last),
    .s_fire   (s_fire)
  );

  // numerator lane: weighted moment terms
  maxdot_mac_lane #(.WGT_W(P_WGT_W), .TERM_W(P_MOM_W), .ACC_W(NUM_W)) u_num_lane (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (s_fire),
    .step_last (s_last),
    .weight    (s_omega),
    .term      (cons_moment),
    .total     (num_total)
  );

  // denominator lane: weighted area terms
  maxdot_mac_lane #(.WGT_W(P_WGT_W), .TERM_W(P_AREA_W), .ACC_W(DEN_W)) u_den_lane (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (s_fire),
    .step_last (s_last),
    .weight    (s_omega),
    .term      (cons_area),
    .total     (den_total)
  );

  maxdot_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W), .Q_W(P_OUT_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (num_total),
    .den   (den_total),
    .busy  (div_busy),
    .done  (div_done),
    .quot  (div_quot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q   <= 1'b0;
      value_q    <= '0;
      index_q    <= '0;
      next_idx_q <= '0;
    end else begin
      strobe_q <= div_done;
      if (div_done) begin
        value_q    <= div_quot;
        index_q    <= next_idx_q;
        next_idx_q <= (next_idx_q == cfg_last_idx) ? '0 : next_idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eop_q <= 1'b0;
    end else if (strobe_q) begin
      if (index_q == cfg_last_idx) begin
        eop_q <= 1'b0;
      end else if ((cfg_last_idx != '0) && (index_q == P_IDX_W'(cfg_last_idx - 1'b1))) begin
        eop_q <= 1'b1;
      end
    end
  end

  assign out_strobe = strobe_q;
  assign out_value  = value_q;
  assign out_index  = index_q;
  assign out_eop    = eop_q || (strobe_q && (cfg_last_idx == '0));
endmodule

// File: rtl/maxdot_defuzzifier_chk.sv
module maxdot_defuzzifier_chk #(
  parameter int P_WGT_W     = 8,
  parameter int P_CIDX_W    = 5,
  parameter int P_IDX_W     = 4,
  parameter int P_OUT_W     = 10,
  parameter int P_MAX_TERMS = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [P_IDX_W-1:0]  cfg_last_idx,
  input logic                in_valid,
  input logic                in_ready,
  input logic [P_WGT_W-1:0]  in_omega,
  input logic [P_CIDX_W-1:0] in_cidx,
  input logic                in_last,
  input logic                out_strobe,
  input logic [P_OUT_W-1:0]  out_value,
  input logic [P_IDX_W-1:0]  out_index,
  input logic                out_eop
);
  localparam int TC_W = $clog2(P_MAX_TERMS + 1);

  logic            accept;
  logic [TC_W-1:0] tcnt_q;

  assign accept = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tcnt_q <= '0;
    else if (accept) tcnt_q <= in_last ? '0 : tcnt_q + 1'b1;
  end

  AST_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> (in_valid && $stable(in_omega) && $stable(in_cidx) && $stable(in_last))); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (int'(tcnt_q) < P_MAX_TERMS)); // R6
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_strobe |=> !out_strobe); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_strobe |-> ($stable(out_value) && $stable(out_index))); // R8
  AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_strobe |-> (out_index <= cfg_last_idx)); // R9
  AST_EOP_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_strobe && (cfg_last_idx != '0) && (int'(out_index) == int'(cfg_last_idx) - 1)) |=> out_eop); // R10
  AST_EOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_strobe && (out_index == cfg_last_idx)) |=> !out_eop); // R10
endmodule

bind maxdot_defuzzifier maxdot_defuzzifier_chk #(
  .P_WGT_W(P_WGT_W), .P_CIDX_W(P_CIDX_W), .P_IDX_W(P_IDX_W),
  .P_OUT_W(P_OUT_W), .P_MAX_TERMS(P_MAX_TERMS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_last_idx(cfg_last_idx),
  .in_valid(in_valid), .in_ready(in_ready), .in_omega(in_omega),
  .in_cidx(in_cidx), .in_last(in_last), .out_strobe(out_strobe),
  .out_value(out_value), .out_index(out_index), .out_eop(out_eop)
);

// File: tb/maxdot_defuzzifier_tb_top.sv
`timescale 1ns/1ps
module maxdot_defuzzifier_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_last_idx = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_omega = '0;
  logic [4:0]  in_cidx = '0;
  logic        in_last = 1'b0;
  logic [4:0]  cons_addr;
  logic [7:0]  cons_area;
  logic [17:0] cons_moment;
  logic        out_strobe;
  logic [9:0]  out_value;
  logic [3:0]  out_index;
  logic        out_eop;

  int checks = 0;
  int failures = 0;

  logic [7:0]  mem_area [32];
  logic [17:0] mem_mom  [32];

  int t_om [16];
  int t_ci [16];
  int exp_val [64];
  int exp_idx [64];
  int got_val [64];
  int got_idx [64];
  int exp_n = 0, got_n = 0, cmp_n = 0, bench_idx = 0;
  bit saw_stall = 0;
  bit eop_state = 0;
  bit prev_strobe = 0;
  int held_val = 0, held_idx = 0;

  always #5 clk = ~clk;

  assign cons_area   = mem_area[cons_addr];
  assign cons_moment = mem_mom[cons_addr];

  maxdot_defuzzifier dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_last_idx(cfg_last_idx),
    .in_valid(in_valid), .in_ready(in_ready), .in_omega(in_omega),
    .in_cidx(in_cidx), .in_last(in_last), .cons_addr(cons_addr),
    .cons_area(cons_area), .cons_moment(cons_moment),
    .out_strobe(out_strobe), .out_value(out_value),
    .out_index(out_index), .out_eop(out_eop)
  );

  task automatic check(input string rq, input int act, input int expv, input string what);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, expv);
    end
  endtask

  // output monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_eop;
      exp_eop = eop_state || (out_strobe && cfg_last_idx == 0);
      if (out_strobe || prev_strobe) check("R10", out_eop, exp_eop, "eop level");
      if (out_strobe) begin
        check("R7", prev_strobe, 0, "strobe in adjacent cycles");
        if (got_n < 64) begin
          got_val[got_n] = out_value;
          got_idx[got_n] = out_index;
        end
        got_n++;
        held_val = out_value;
        held_idx = out_index;
        if (cfg_last_idx != 0 && out_index == cfg_last_idx - 1) eop_state = 1;
        if (out_index == cfg_last_idx) eop_state = 0;
      end else begin
        check("R8", out_value, held_val, "value held between strobes");
        check("R8", out_index, held_idx, "index held between strobes");
      end
      prev_strobe = out_strobe;
    end
  end

  task automatic send_term(input int om, input int ci, input bit last);
    @(negedge clk);
    in_valid = 1'b1; in_omega = 8'(om); in_cidx = 5'(ci); in_last = last;
    #1;
    while (!in_ready) begin
      saw_stall = 1;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", cons_addr, ci, "table address after accept");
  endtask

  task automatic send_output(input int n);
    longint num = 0, den = 0, q;
    for (int k = 0; k < n; k++) begin
      num += longint'(t_om[k]) * longint'(mem_mom[t_ci[k]]);
      den += longint'(t_om[k]) * longint'(mem_area[t_ci[k]]);
    end
    if (den == 0) q = 0;
    else begin
      q = num / den;
      if (q > 1023) q = 1023;
    end
    exp_val[exp_n] = int'(q);
    exp_idx[exp_n] = bench_idx;
    exp_n++;
    bench_idx = (bench_idx == cfg_last_idx) ? 0 : bench_idx + 1;
    for (int k = 0; k < n; k++) send_term(t_om[k], t_ci[k], k == n - 1);
  endtask

  task automatic collect(input string rq);
    int waited = 0;
    while (got_n < exp_n && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    check(rq, got_n, exp_n, "result count");
    for (int i = cmp_n; i < exp_n && i < got_n; i++) begin
      check(rq, got_val[i], exp_val[i], "result value");
      check("R9", got_idx[i], exp_idx[i], "result index");
    end
    cmp_n = exp_n;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R11", out_strobe, 0, "strobe after reset");
    check("R11", out_eop, 0, "eop after reset");
    check("R11", out_value, 0, "value after reset");
    check("R11", out_index, 0, "index after reset");
    check("R1", in_ready, 1, "ready after reset");
  endtask

  task automatic t_single();
    cfg_last_idx = 0;
    t_om[0] = 200; t_ci[0] = 3;
    t_om[1] = 50;  t_ci[1] = 7;
    t_om[2] = 120; t_ci[2] = 12;
    send_output(3);
    collect("R3");
  endtask

  task automatic t_multi();
    cfg_last_idx = 3;
    t_om[0] = 255; t_ci[0] = 1;
    send_output(1);
    for (int k = 0; k < 4; k++) begin t_om[k] = 30 + 40 * k; t_ci[k] = 2 + 5 * k; end
    send_output(4);
    for (int k = 0; k < 16; k++) begin t_om[k] = (k * 53 + 9) % 256; t_ci[k] = (k * 7) % 30; end
    send_output(16);
    t_om[0] = 17; t_ci[0] = 25; t_om[1] = 90; t_ci[1] = 4;
    send_output(2);
    collect("R3");
  endtask

  task automatic t_zero_and_sat();
    cfg_last_idx = 1;
    for (int k = 0; k < 3; k++) begin t_om[k] = 0; t_ci[k] = 5 + k; end
    send_output(3);
    collect("R4");
    t_om[0] = 10; t_ci[0] = 30;
    send_output(1);
    collect("R5");
  endtask

  task automatic t_backpressure();
    cfg_last_idx = 2;
    saw_stall = 0;
    for (int j = 0; j < 3; j++) begin
      t_om[0] = 60 + 50 * j; t_ci[0] = 9 + j;
      send_output(1);
    end
    check("R1", saw_stall, 1, "ready dropped while divider busy");
    collect("R3");
  endtask

  task automatic t_widest();
    cfg_last_idx = 0;
    for (int k = 0; k < 16; k++) begin t_om[k] = 255; t_ci[k] = 31; end
    send_output(16);
    collect("R6");
  endtask

  initial begin
    for (int i = 0; i < 30; i++) begin
      int a, c;
      a = 1 + (i * 37) % 255;
      c = (i * 97 + 5) % 1024;
      mem_area[i] = 8'(a);
      mem_mom[i]  = 18'(a * c);
    end
    mem_area[30] = 8'd1;   mem_mom[30] = 18'd5000;
    mem_area[31] = 8'd255; mem_mom[31] = 18'(255 * 1023);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_multi();
    t_zero_and_sat();
    t_backpressure();
    t_widest();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule